// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

This block is a small 2D drawing engine for a linear frame buffer. Software sets it up through nine word registers, selected by a 4-bit index. Index 0 holds the colour, 1 the raster-op code and 2 the command. Index 3 describes the surface. Indices 4 and 5 are the two source corners and 6 and 7 the two destination corners. Index 8 is a read-only status word. Writing destination corner 2 launches the job. The engine then moves pixel by pixel through the destination rectangle. It reads the source and, when needed, the destination through a single-request memory port, and writes the result back.

The engine can fill a rectangle with a solid colour, or copy one rectangle of the surface onto another. Either operation can replace the destination or XOR into it. The command carries a walk-direction bit, and software places the rectangle's corners to match it. Set this way, a copy between overlapping rectangles reads every source pixel before that pixel is overwritten.

Top module: `rect_blitter`

## Requirements
- R1: A corner word carries y in bits 31:16 and x in bits 15:0. Both corners of a rectangle are inclusive, so a job writes exactly (|x2-x1|+1)*(|y2-y1|+1) pixels, each one once.
- R2: The surface word holds the base byte address in bits 19:0, the pitch in units of 8 pixels in bits 28:20, and the depth code in bits 31:29. Depth code 0 is 1 byte per pixel, 1 is 2 bytes, and 2 or more is 4 bytes. Each access goes to byte address base + (y*pitch_pixels + x)*bytes, and mem_size carries 0, 1 or 2 for 1, 2 or 4 bytes.
- R3: A fill whose raster-op code is anything other than 0x66 writes the colour, truncated to the pixel width. Codes 0xCC and 0x12 both act this way.
- R4: With raster-op code 0x66, the engine first reads the destination pixel. A fill then writes colour XOR destination, and a copy writes source XOR destination.
- R5: With command bit 0 clear, the walk starts at corner 2 and moves toward corner 1. x decreases along each row, and y decreases at each row change. A copy whose corners follow the direction rule below gives the same result as copying from an untouched source.
- R6: With command bit 0 set, the walk starts at corner 2 and increases x, then y, toward corner 1. Software sets this bit, with the bottom-right corners in the corner-1 registers, when the source row is below the destination row, or when the rows are equal and the source x is greater.
- R7: A write to index 7 while idle starts a job only if command bits 3:2 equal 2 (fill) or 1 (copy). Any other code starts nothing and makes no memory access.
- R8: Status bit 31 is busy; the other status bits read 0. Busy is high from the cycle after the starting write, and goes low in the cycle after the last pixel write is accepted.
- R9: Register writes made while busy are ignored. They change neither the register contents read back nor the pixels of the running job.
- R10: A memory request holds its address, size and type until mem_ready accepts it. Read data is taken from mem_rdata in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the pixel |
| mem_size | output | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata | output | 32 | Pixel write data, right-aligned |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | 32 | Read data, valid the cycle after a read is accepted |

## Verification
The checks assume that software sets corner 1 and corner 2 in the order the direction bit implies. When that order is wrong, the walk wraps around the 16-bit coordinate space instead of ending. They also assume that the memory returns read data exactly one cycle after accepting a read. The bench only builds jobs in which both rectangles derive from one top-left point, a width and a height. It applies the direction rule itself when it picks corner order, and its memory model follows the one-cycle return with a pseudo-random ready. All pixels stay inside a 4 KiB window, so address truncation never aliases two pixels of one job.

// File: rtl/rect_blitter.sv
module rect_blitter #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam logic [3:0] IX_COLOR = 4'd0, IX_ROP = 4'd1, IX_CMD = 4'd2, IX_SURF = 4'd3,
                         IX_SRC_A = 4'd4, IX_SRC_B = 4'd5, IX_DST_A = 4'd6, IX_DST_B = 4'd7,
                         IX_STAT = 4'd8;
  localparam logic [7:0] ROP_XOR = 8'h66;
  localparam logic [1:0] OP_COPY = 2'd1, OP_FILL = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RSRC, S_WSRC, S_RDST, S_WDST, S_WR} st_t;
  st_t state, first_st;

  logic [31:0] color_q, surf_q, src_a, src_b, dst_a, dst_b;
  logic [7:0]  rop_q;
  logic [1:0]  op_q;
  logic        asc_q;
  logic [15:0] cx, cy, sx, sy;
  logic [31:0] src_q, dst_q;

  logic busy, is_copy, is_xor, start, row_end, last;
  assign busy    = (state != S_IDLE);
  assign is_copy = (op_q == OP_COPY);
  assign is_xor  = (rop_q == ROP_XOR);
  assign start   = reg_we && !busy && (reg_addr == IX_DST_B) &&
                   ((op_q == OP_COPY) || (op_q == OP_FILL));
  assign first_st = is_copy ? S_RSRC : (is_xor ? S_RDST : S_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '0; surf_q <= '0; rop_q <= '0; op_q <= '0; asc_q <= 1'b0;
      src_a <= '0; src_b <= '0; dst_a <= '0; dst_b <= '0;
    end else if (reg_we && !busy) begin
      case (reg_addr)
        IX_COLOR: color_q <= reg_wdata;
        IX_ROP:   rop_q   <= reg_wdata[7:0];
        IX_CMD:   begin op_q <= reg_wdata[3:2]; asc_q <= reg_wdata[0]; end
        IX_SURF:  surf_q  <= reg_wdata;
        IX_SRC_A: src_a   <= reg_wdata;
        IX_SRC_B: src_b   <= reg_wdata;
        IX_DST_A: dst_a   <= reg_wdata;
        IX_DST_B: dst_b   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      IX_COLOR: reg_rdata = color_q;
      IX_ROP:   reg_rdata = {24'd0, rop_q};
      IX_CMD:   reg_rdata = {28'd0, op_q, 1'b0, asc_q};
      IX_SURF:  reg_rdata = surf_q;
      IX_SRC_A: reg_rdata = src_a;
      IX_SRC_B: reg_rdata = src_b;
      IX_DST_A: reg_rdata = dst_a;
      IX_DST_B: reg_rdata = dst_b;
      IX_STAT:  reg_rdata = {busy, 31'd0};
      default:  reg_rdata = 32'd0;
    endcase
  end

  logic [1:0]  shift;
  logic [31:0] pitch_px, pmask, lin, pix;
  logic [15:0] ax, ay, nx, ny, nsx, nsy;
  assign shift    = (surf_q[31:29] >= 3'd2) ? 2'd2 : {1'b0, surf_q[29]};
  assign pitch_px = {20'd0, surf_q[28:20], 3'd0};
  assign pmask    = (shift == 2'd0) ? 32'h0000_00FF : (shift == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign ax       = (state == S_RSRC) ? sx : cx;
  assign ay       = (state == S_RSRC) ? sy : cy;
  assign lin      = 32'(ay) * pitch_px + 32'(ax);
  assign mem_addr = ADDR_W'({12'd0, surf_q[19:0]} + (lin << shift));
  assign mem_size = shift;
  assign mem_req  = (state == S_RSRC) || (state == S_RDST) || (state == S_WR);
  assign mem_we   = (state == S_WR);
  assign pix      = is_copy ? src_q : color_q;
  assign mem_wdata = (is_xor ? (pix ^ dst_q) : pix) & pmask;

  assign row_end = (cx == dst_a[15:0]);
  assign last    = row_end && (cy == dst_a[31:16]);
  assign nx  = asc_q ? cx + 16'd1 : cx - 16'd1;
  assign ny  = asc_q ? cy + 16'd1 : cy - 16'd1;
  assign nsx = asc_q ? sx + 16'd1 : sx - 16'd1;
  assign nsy = asc_q ? sy + 16'd1 : sy - 16'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cx <= '0; cy <= '0; sx <= '0; sy <= '0;
      src_q <= '0; dst_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cx <= reg_wdata[15:0]; cy <= reg_wdata[31:16];
          sx <= src_b[15:0];     sy <= src_b[31:16];
          state <= first_st;
        end
        S_RSRC: if (mem_ready) state <= S_WSRC;
        S_WSRC: begin
          src_q <= mem_rdata;
          state <= is_xor ? S_RDST : S_WR;
        end
        S_RDST: if (mem_ready) state <= S_WDST;
        S_WDST: begin
          dst_q <= mem_rdata;
          state <= S_WR;
        end
        S_WR: if (mem_ready) begin
          if (last) state <= S_IDLE;
          else begin
            state <= first_st;
            if (row_end) begin
              cx <= dst_b[15:0]; sx <= src_b[15:0];
              cy <= ny;          sy <= nsy;
            end else begin
              cx <= nx; sx <= nsx;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_we && mem_ready));
  // R7
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == IX_DST_B && (op_q == OP_COPY || op_q == OP_FILL)) |=> busy);
  // R7
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == IX_DST_B && op_q != OP_COPY && op_q != OP_FILL) |=> !busy);
  // R9
  regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(color_q) && $stable(rop_q) && $stable(surf_q) && $stable(dst_a)));
endmodule

// File: tb/rect_blitter_tb.sv
module rect_blitter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd8;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ready;
  logic [23:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  rect_blitter #(.ADDR_W(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  logic [7:0] mem [0:4095];
  logic [7:0] orig [0:4095];
  logic [7:0] refm [0:4095];
  int wlog [0:4095];
  int wcnt = 0, rcnt = 0, cyc = 0, last_acc = 0, seed = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic init_go = 1'b0;
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= rst_n && (lfsr[0] | lfsr[1]);
    if (init_go) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'((i * 37) + (seed * 11) + (i >> 3));
    end else if (mem_req && mem_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (b < (1 << mem_size)) mem[(int'(mem_addr[11:0]) + b) & 4095] <= mem_wdata[8*b +: 8];
        wlog[wcnt & 4095] <= int'(mem_addr[11:0]);
        wcnt <= wcnt + 1;
        last_acc <= cyc + 1;
      end else begin
        rcnt <= rcnt + 1;
        mem_rdata <= {mem[(int'(mem_addr[11:0]) + 3) & 4095], mem[(int'(mem_addr[11:0]) + 2) & 4095],
                      mem[(int'(mem_addr[11:0]) + 1) & 4095], mem[int'(mem_addr[11:0])]};
      end
    end
  end

  initial begin
    #1_200_000;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 4'd8;
  endtask

  task automatic fill_mem(input int s);
    seed = s;
    @(negedge clk); init_go = 1'b1;
    @(negedge clk); init_go = 1'b0;
  endtask

  function automatic logic [31:0] pt(input int x, input int y);
    return {16'(y), 16'(x)};
  endfunction

  function automatic int paddr(input int base, input int pp, input int bpp, input int x, input int y);
    return (base + (y * pp + x) * bpp) & 4095;
  endfunction

  function automatic logic [31:0] opix(input int a);
    return {orig[(a + 3) & 4095], orig[(a + 2) & 4095], orig[(a + 1) & 4095], orig[a]};
  endfunction

  task automatic blit(input int d, input int pf, input int base, input int op, input int rop,
                      input logic [31:0] col, input int sx, input int sy, input int dx, input int dy,
                      input int w, input int h, input bit fasc, input bit poke, input string tag);
    int pp, bpp, ws, bad, first_bad, k, timeout;
    bit asc;
    logic [31:0] c1s, c2s, c1d, c2d, pm, v;
    pp = pf * 8; bpp = (d >= 2) ? 4 : (1 << d);
    pm = (bpp == 1) ? 32'hFF : (bpp == 2) ? 32'hFFFF : 32'hFFFFFFFF;
    asc = (op == 1) ? ((sy > dy) || (sy == dy && sx > dx)) : fasc;
    c1s = asc ? pt(sx + w - 1, sy + h - 1) : pt(sx, sy);
    c2s = asc ? pt(sx, sy) : pt(sx + w - 1, sy + h - 1);
    c1d = asc ? pt(dx + w - 1, dy + h - 1) : pt(dx, dy);
    c2d = asc ? pt(dx, dy) : pt(dx + w - 1, dy + h - 1);
    wr(4'd3, {3'(d), 9'(pf), 20'(base)});
    wr(4'd0, col); wr(4'd1, 32'(rop)); wr(4'd2, 32'((op << 2) | int'(asc)));
    wr(4'd4, c1s); wr(4'd5, c2s); wr(4'd6, c1d);
    for (int i = 0; i < 4096; i++) begin orig[i] = mem[i]; refm[i] = mem[i]; end
    ws = wcnt;
    wr(4'd7, c2d);
    #1;
    chk(reg_rdata[31] == 1'b1, "R8", {tag, " busy after start"}, reg_rdata[31], 1);
    chk(reg_rdata[30:0] == 31'd0, "R8", {tag, " status spare bits"}, reg_rdata[30:0], 0);
    if (poke) begin
      wr(4'd0, ~col);
      wr(4'd7, pt(0, 0));
      #1;
    end
    timeout = 0;
    while (reg_rdata[31] && timeout < 5000) begin
      @(negedge clk); #1; timeout++;
    end
    chk(cyc == last_acc, "R8", {tag, " busy drop cycle"}, cyc, last_acc);
    for (int yy = 0; yy < h; yy++)
      for (int xx = 0; xx < w; xx++) begin
        k = paddr(base, pp, bpp, dx + xx, dy + yy);
        v = (op == 1) ? opix(paddr(base, pp, bpp, sx + xx, sy + yy)) : col;
        if (rop == 'h66) v = v ^ opix(k);
        v = v & pm;
        for (int b = 0; b < bpp; b++) refm[(k + b) & 4095] = v[8*b +: 8];
      end
    bad = 0; first_bad = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== refm[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (first_bad < 0) first_bad = 0;
    chk(bad == 0, (rop == 'h66) ? "R4" : ((op == 1) ? (asc ? "R6" : "R5") : "R3"),
        {tag, " image (R2 addressing)"}, mem[first_bad], refm[first_bad]);
    chk(wcnt - ws == w * h, "R1", {tag, " pixel writes"}, wcnt - ws, w * h);
    bad = 0; k = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        if (wlog[(ws + k) & 4095] != paddr(base, pp, bpp, asc ? dx + c : dx + w - 1 - c, asc ? dy + r : dy + h - 1 - r)) bad++;
        k++;
      end
    chk(bad == 0, asc ? "R6" : "R5", {tag, " walk order"}, bad, 0);
    if (poke) begin
      reg_addr = 4'd0; #1;
      chk(reg_rdata == col, "R9", {tag, " colour kept"}, reg_rdata, col);
      reg_addr = 4'd7; #1;
      chk(reg_rdata == c2d, "R9", {tag, " corner kept"}, reg_rdata, c2d);
      reg_addr = 4'd8;
    end
  endtask

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    #1;
    chk(reg_rdata == 32'd0, "R8", "status after reset", reg_rdata, 0);
    chk(mem_req == 1'b0, "R10", "no request after reset", mem_req, 0);
    reg_addr = 4'd0; #1;
    chk(reg_rdata == 32'd0, "R9", "colour after reset", reg_rdata, 0);
    reg_addr = 4'd8;
    rst_n = 1'b1;
    for (int d = 0; d < 3; d++) begin
      fill_mem(d + 1);
      blit(d, 2, 'h40, 2, 'hCC, 32'hA5C3E187, 0, 0, 3, 2, 5, 3, 1'b0, 1'b1, "fill copy-rop");
      blit(d, 3, 'h10, 2, 'h66, 32'h5AF00F3C, 0, 0, 1, 4, 4, 2, 1'b1, 1'b0, "fill xor asc");
      blit(d, 2, 0, 2, 'h12, 32'h13579BDF, 0, 0, 6, 5, 2, 4, 1'b0, 1'b0, "fill other rop");
      for (int oy = -1; oy <= 1; oy++)
        for (int ox = -2; ox <= 2; ox += 2) begin
          fill_mem(d * 16 + oy * 4 + ox + 7);
          blit(d, 2, 'h20, 1, 'hCC, 0, 4, 3, 4 + ox, 3 + oy, 4, 3, 1'b0, 1'b0, "copy overlap");
        end
      blit(d, 3, 0, 1, 'h66, 0, 1, 1, 9, 6, 3, 2, 1'b0, 1'b0, "copy xor");
      blit(d, 3, 0, 1, 'h66, 0, 9, 6, 10, 6, 3, 2, 1'b0, 1'b0, "copy xor right");
    end
    for (int op = 0; op < 4; op += 3) begin
      w0 = wcnt; r0 = rcnt;
      wr(4'd2, 32'(op << 2));
      wr(4'd7, pt(3, 3));
      #1;
      chk(reg_rdata[31] == 1'b0, "R7", "bad op no busy", reg_rdata[31], 0);
      repeat (6) @(negedge clk);
      chk(wcnt == w0 && rcnt == r0, "R7", "bad op no access", wcnt + rcnt, w0 + r0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule